// File: doc/BRIEF.md
# Serial Digit and Bit Timing Generator

This block produces every timing strobe that a bit-serial BCD datapath needs, all derived from a single master bit clock. Each clock is one bit time. Four consecutive bit times make one digit slot, with the least significant weight first, and sixteen digit slots make one number cycle. The block drives a one-hot strobe for the current bit phase and another for the current digit slot. It also drives a shift enable for the serial registers, a flag that marks slots mapped to displayed digits, and a one-clock pulse that marks the final bit of each number cycle.

Slot 0 of every cycle is a non-shifting gap. The serial registers hold still for all four bit phases of that slot, which gives the surrounding control logic a quiet interval at each cycle boundary. Only slots 2 through 15 carry displayed digits. Slot 1 shifts but is not shown.

Reset is asynchronous and active low. It is released through a two-stage synchronizer, so the generator always begins counting from bit 0 of slot 0 at a known edge.

Top module: `serial_timing_gen`

## Requirements
- R1: While `rst_ni` is low, `bit_stb_o` is 4'b0001, `slot_stb_o` is 16'h0001, and `shift_en_o`, `disp_slot_o` and `cycle_end_o` are all 0.
- R2: After `rst_ni` rises, the outputs keep their reset values through the first two rising clock edges. The first advance, to bit phase 1, happens on the third rising edge.
- R3: Exactly one bit of `bit_stb_o` is high at any time. Bit k marks the phase that carries weight 2^k. The phases run 0, 1, 2, 3 and then repeat, one clock each.
- R4: Exactly one bit of `slot_stb_o` is high at any time. Bit k marks digit slot k. The slot advances by one on the clock after bit phase 3 and wraps from 15 to 0.
- R5: `shift_en_o` is low in all four bit phases of slot 0 and high in every bit phase of slots 1 to 15. This gives 60 shifting clocks per 64-clock cycle.
- R6: `disp_slot_o` is high exactly in slots 2 to 15 and low in slots 0 and 1. This gives 56 clocks per cycle.
- R7: `cycle_end_o` is high for exactly one clock per 64, in bit phase 3 of slot 15. The following clock is bit phase 0 of slot 0.
- R8: Asserting `rst_ni` in the middle of a cycle returns every output to its R1 value at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_stb_o | output | 4 | One-hot bit phase strobe, bit k for weight 2^k |
| slot_stb_o | output | 16 | One-hot digit slot strobe, bit k for slot k |
| shift_en_o | output | 1 | Serial register shift enable, low during the gap slot |
| disp_slot_o | output | 1 | High in slots that map to displayed digits |
| cycle_end_o | output | 1 | One-clock pulse in the last bit of the last slot |

## Verification
The assertions check the following on every clock:
- both strobe vectors stay one-hot;
- the bit phase steps through its fixed order;
- the slot holds still except on the step after phase 3;
- the shift enable and the display flag agree with the current slot;
- the end pulse appears only in the final bit of the final slot and is followed by the first bit of slot 0.

Some behaviours only the bench scenarios can show. One is the exact edge at which counting starts after reset is released. Another is the immediate return to the reset state when reset is asserted between edges. The last is the per-cycle totals of shifting, displayed and end-marker clocks, which are counted over whole cycles.

// File: rtl/serial_timing_pkg.sv
package serial_timing_pkg;

  // Default geometry of a number cycle.
  localparam int unsigned DFLT_BITS_PER_DIGIT = 4;
  localparam int unsigned DFLT_SLOTS_PER_CYC  = 16;
  localparam int unsigned DFLT_GAP_SLOT       = 0;
  localparam int unsigned DFLT_FIRST_SHOWN    = 2;
  localparam int unsigned DFLT_SYNC_STAGES    = 2;

endpackage

// File: rtl/serial_rst_sync.sv
module serial_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // Shift ones in from the bottom of the chain.
  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/serial_bit_phase.sv
module serial_bit_phase #(
  parameter int unsigned BITS = 4,
  localparam int unsigned BW  = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [BITS-1:0] phase_oh_o,
  output logic            phase_last_o
);

  logic [BW-1:0] phase_q;
  logic [BW-1:0] phase_d;
  logic          at_last;

  assign at_last = (phase_q == BW'(BITS - 1));

  // Next-state process: wrap explicitly so non-power-of-two sizes also work.
  always_comb begin
    if (at_last) phase_d = '0;
    else         phase_d = phase_q + BW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_d;
  end

  for (genvar g = 0; g < BITS; g++) begin : g_dec
    assign phase_oh_o[g] = (phase_q == BW'(g));
  end

  assign phase_last_o = at_last;

endmodule

// File: rtl/serial_slot_ctr.sv
module serial_slot_ctr #(
  parameter int unsigned SLOTS = 16,
  localparam int unsigned SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [SW-1:0]    slot_idx_o,
  output logic [SLOTS-1:0] slot_oh_o,
  output logic             slot_last_o
);

  logic [SW-1:0] slot_q;
  logic [SW-1:0] slot_d;
  logic          at_last;

  assign at_last = (slot_q == SW'(SLOTS - 1));

  // Next-state process with the clock enable written out.
  always_comb begin
    slot_d = slot_q;
    if (step_i) begin
      if (at_last) slot_d = '0;
      else         slot_d = slot_q + SW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_d;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_dec
    assign slot_oh_o[g] = (slot_q == SW'(g));
  end

  assign slot_idx_o  = slot_q;
  assign slot_last_o = at_last;

endmodule

// File: rtl/serial_slot_qual.sv
module serial_slot_qual #(
  parameter int unsigned SLOTS       = 16,
  parameter int unsigned GAP_SLOT    = 0,
  parameter int unsigned FIRST_SHOWN = 2,
  localparam int unsigned SW         = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SW-1:0] slot_idx_i,
  input  logic          slot_last_i,
  input  logic          phase_last_i,
  output logic          shift_en_o,
  output logic          disp_slot_o,
  output logic          cycle_end_o
);

  always_comb begin
    shift_en_o  = (slot_idx_i != SW'(GAP_SLOT));
    disp_slot_o = (slot_idx_i >= SW'(FIRST_SHOWN));
    cycle_end_o = slot_last_i & phase_last_i;
  end

endmodule

// File: rtl/serial_timing_gen.sv
module serial_timing_gen
  import serial_timing_pkg::*;
#(
  parameter int unsigned BITS_PER_DIGIT = DFLT_BITS_PER_DIGIT,
  parameter int unsigned SLOTS_PER_CYC  = DFLT_SLOTS_PER_CYC,
  parameter int unsigned GAP_SLOT       = DFLT_GAP_SLOT,
  parameter int unsigned FIRST_SHOWN    = DFLT_FIRST_SHOWN,
  parameter int unsigned SYNC_STAGES    = DFLT_SYNC_STAGES
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  output logic [BITS_PER_DIGIT-1:0] bit_stb_o,
  output logic [SLOTS_PER_CYC-1:0]  slot_stb_o,
  output logic                      shift_en_o,
  output logic                      disp_slot_o,
  output logic                      cycle_end_o
);

  localparam int unsigned SW = (SLOTS_PER_CYC > 1) ? $clog2(SLOTS_PER_CYC) : 1;

  logic          rst_sync_n;
  logic          phase_last;
  logic          slot_last;
  logic [SW-1:0] slot_idx;

  serial_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  serial_bit_phase #(
    .BITS (BITS_PER_DIGIT)
  ) u_bit_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .phase_oh_o   (bit_stb_o),
    .phase_last_o (phase_last)
  );

  serial_slot_ctr #(
    .SLOTS (SLOTS_PER_CYC)
  ) u_slot_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .step_i      (phase_last),
    .slot_idx_o  (slot_idx),
    .slot_oh_o   (slot_stb_o),
    .slot_last_o (slot_last)
  );

  serial_slot_qual #(
    .SLOTS       (SLOTS_PER_CYC),
    .GAP_SLOT    (GAP_SLOT),
    .FIRST_SHOWN (FIRST_SHOWN)
  ) u_qual (
    .slot_idx_i   (slot_idx),
    .slot_last_i  (slot_last),
    .phase_last_i (phase_last),
    .shift_en_o   (shift_en_o),
    .disp_slot_o  (disp_slot_o),
    .cycle_end_o  (cycle_end_o)
  );

endmodule

// File: rtl/serial_timing_chk.sv
module serial_timing_chk #(
  parameter int unsigned BITS_PER_DIGIT = 4,
  parameter int unsigned SLOTS_PER_CYC  = 16,
  parameter int unsigned GAP_SLOT       = 0,
  parameter int unsigned FIRST_SHOWN    = 2
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [BITS_PER_DIGIT-1:0] bit_stb_o,
  input logic [SLOTS_PER_CYC-1:0]  slot_stb_o,
  input logic                      shift_en_o,
  input logic                      disp_slot_o,
  input logic                      cycle_end_o
);

  localparam int unsigned LB = BITS_PER_DIGIT - 1;
  localparam int unsigned LS = SLOTS_PER_CYC - 1;

  logic shown_slot;
  assign shown_slot = |(slot_stb_o >> FIRST_SHOWN);

  AST_BIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(bit_stb_o) == 1); // R3
  AST_BIT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o[LB] |=> bit_stb_o[0]); // R3
  AST_SLOT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(slot_stb_o) == 1); // R4
  AST_SLOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_stb_o[LB] |=> $stable(slot_stb_o)); // R4
  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_o[LB] && !slot_stb_o[LS]) |=> (slot_stb_o == ($past(slot_stb_o) << 1))); // R4
  AST_GAP_NO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_o == !slot_stb_o[GAP_SLOT]); // R5
  AST_DISP_SLOTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_slot_o == shown_slot); // R6
  AST_END_PLACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_end_o |-> (bit_stb_o[LB] && slot_stb_o[LS])); // R7
  AST_END_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_end_o |=> (bit_stb_o[0] && slot_stb_o[0] && !cycle_end_o)); // R7

endmodule

bind serial_timing_gen serial_timing_chk #(
  .BITS_PER_DIGIT (BITS_PER_DIGIT),
  .SLOTS_PER_CYC  (SLOTS_PER_CYC),
  .GAP_SLOT       (GAP_SLOT),
  .FIRST_SHOWN    (FIRST_SHOWN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bit_stb_o   (bit_stb_o),
  .slot_stb_o  (slot_stb_o),
  .shift_en_o  (shift_en_o),
  .disp_slot_o (disp_slot_o),
  .cycle_end_o (cycle_end_o)
);

// File: tb/serial_timing_gen_tb.sv
module serial_timing_gen_tb;

  localparam int CLK_T = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  bit_stb_o;
  logic [15:0] slot_stb_o;
  logic        shift_en_o;
  logic        disp_slot_o;
  logic        cycle_end_o;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;   // rising edges since the last reset release

  always #(CLK_T/2) clk_i = ~clk_i;

  serial_timing_gen u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_stb_o   (bit_stb_o),
    .slot_stb_o  (slot_stb_o),
    .shift_en_o  (shift_en_o),
    .disp_slot_o (disp_slot_o),
    .cycle_end_o (cycle_end_o)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected outputs after n advances (R2: advances begin at the third edge).
  task automatic chk_pos(input string req, input int n);
    int b, s;
    b = n % 4;
    s = (n / 4) % 16;
    chk(req, "bit_stb",   16'(bit_stb_o),  16'(1 << b));
    chk(req, "slot_stb",  slot_stb_o,      16'(1 << s));
    chk(req, "shift_en",  16'(shift_en_o), 16'(s != 0));
    chk(req, "disp_slot", 16'(disp_slot_o), 16'(s >= 2));
    chk(req, "cycle_end", 16'(cycle_end_o), 16'((n % 64) == 63));
  endtask

  function automatic int adv();
    return (edges > 2) ? edges - 2 : 0;
  endfunction

  task automatic step();
    @(posedge clk_i);
    edges++;
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    edges = 0;
  endtask

  // R1: values held while reset is low
  task automatic t_reset_state();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) begin
      @(negedge clk_i);
      chk_pos("R1", 0);
    end
    rst_ni = 1'b1;
    edges = 0;
  endtask

  // R2: two held edges, first advance on the third
  task automatic t_release();
    do_reset();
    step(); chk_pos("R2", 0);
    step(); chk_pos("R2", 0);
    step(); chk_pos("R2", 1);
    chk("R2", "advances", 16'(adv()), 16'd1);
  endtask

  // R3 R4 R5 R6 R7: full sweep over several cycles
  task automatic t_sweep();
    do_reset();
    for (int i = 0; i < 3 * 64 + 5; i++) begin
      step();
      chk_pos("R3_R4_R5_R6_R7", adv());
    end
  endtask

  // R5 R6 R7: per-cycle totals
  task automatic t_totals();
    int sh, dp, ce;
    do_reset();
    step(); step();          // now aligned at bit 0 of slot 0
    for (int c = 0; c < 2; c++) begin
      sh = 0; dp = 0; ce = 0;
      for (int i = 0; i < 64; i++) begin
        sh += int'(shift_en_o);
        dp += int'(disp_slot_o);
        ce += int'(cycle_end_o);
        step();
      end
      chk("R5", "shift clocks per cycle", 16'(sh), 16'd60);
      chk("R6", "display clocks per cycle", 16'(dp), 16'd56);
      chk("R7", "end pulses per cycle", 16'(ce), 16'd1);
    end
  endtask

  // R8: reset between edges clears outputs immediately
  task automatic t_midreset();
    do_reset();
    for (int i = 0; i < 41; i++) step();
    chk_pos("R8", adv());
    #(CLK_T/4);
    rst_ni = 1'b0;
    #1;
    chk_pos("R8", 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    edges = 0;
    for (int i = 0; i < 6; i++) begin
      step();
      chk_pos("R8", adv());
    end
  endtask

  initial begin
    t_reset_state();
    t_release();
    t_sweep();
    t_totals();
    t_midreset();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_T * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule